// File: doc/BRIEF.md
# Pipelined Burst Static Memory Controller

This block is the synchronous front end of a burst-capable static memory. Each word is 36 bits wide and made of four 9-bit byte lanes. Three chip enables select the block. Two address strobes start bursts: one from a processor, one from a controller. An advance strobe steps or holds the burst address. A global write line and per-lane byte-write controls turn each cycle into a read, a write or a deselect. A small behavioural array, sized by a parameter, holds the data.

Reads are pipelined. The addressed word is captured at the access edge and presented from an output register after the following edge. A drive-enable output lets a pad ring or bus model tri-state the data lines. Output enable and an asynchronous sleep input act on that drive enable without waiting for a clock edge. The two low address bits run through a four-beat burst sequencer. It supports a linear order and an interleaved order.

Top module: `pburst_sram`

## Requirements
- R1: While reset is asserted and after its release, dq_drive is low. With no burst started, a cycle with both strobes high performs no access, so a write-enabled cycle then changes no stored word.
- R2: The block is selected only when ce1_n=0, ce2=1 and ce3_n=0. A strobe seen while not selected starts no access: it writes nothing, produces no read data and ends any running burst.
- R3: The processor strobe (adsp_n low) counts only when ce1_n is low. When it counts, it takes priority over the controller strobe, so both strobes low while selected starts a processor burst.
- R4: With both strobes high during a running burst, adv_n=0 moves to the next burst address and adv_n=1 repeats the current one. The write controls pick read or write for that cycle.
- R5: The low two address bits of a burst are start+n (mod 4) when seq_linear=1 and start XOR n when seq_linear=0, where n counts the advances since the start. The upper bits stay at the start address.
- R6: A processor-strobe start is always a read and ignores the write controls. A write to that address completes on the next edge (strobes high, adv_n=1) with the write controls and wdata sampled there.
- R7: A controller-strobe start (adsp_n high) with write controls active writes wdata to addr at that same edge.
- R8: gw_n=0 writes all four lanes whatever bwe_n and bw_n hold.
- R9: With gw_n=1 a write happens only when bwe_n=0, and lane i (bits 9i+8..9i) is written only if bw_n[i]=0. bwe_n=1, or bw_n all ones, makes the cycle a read.
- R10: A read sampled at edge k returns the word as stored before edge k. That word drives dq_out from just after edge k+1 for one cycle.
- R11: dq_drive follows oe_n (active low) combinationally. Output is high-impedance in the cycle after a deselect edge's successor and in the first cycle after a start that follows a deselect. Write cycles produce no driven data.
- R12: sleep=1 forces dq_drive low at once, makes clock edges perform no access and leaves stored words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep | input | 1 | Asynchronous low-power request, active high |
| ce1_n | input | 1 | Chip enable, active low; also gates the processor strobe |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| adsp_n | input | 1 | Processor burst-start strobe, active low |
| adsc_n | input | 1 | Controller burst-start strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write of all lanes, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | LANES | Per-lane write selects, active low |
| seq_linear | input | 1 | Burst order: 1 linear, 0 interleaved |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*LANE_W | Write data |
| dq_out | output | LANES*LANE_W | Output register contents |
| dq_drive | output | 1 | High when dq_out should drive the bus |

## Verification
On every edge the assertions check these points: a deselect leaves the bus undriven two edges later, and a start right after a deselect never drives in its first cycle. They also check that a read started by a strobe shows up two edges later unless oe_n or sleep blocks it, and that writes and sleep edges never lead to driven data. The data values themselves can only be shown by the bench scenarios. Those scenarios cover lane merging, global-write override, the deferred processor-strobe write, both burst orders with suspend and wrap, and the stored contents surviving deselected strobes and sleep. A reference model of the stored words in the bench checks every driven cycle.

// File: rtl/pburst_sram.sv
module pburst_sram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sleep,
  input  logic                    ce1_n,
  input  logic                    ce2,
  input  logic                    ce3_n,
  input  logic                    adsp_n,
  input  logic                    adsc_n,
  input  logic                    adv_n,
  input  logic                    gw_n,
  input  logic                    bwe_n,
  input  logic [LANES-1:0]        bw_n,
  input  logic                    seq_linear,
  input  logic                    oe_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] dq_out,
  output logic                    dq_drive
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int HI_W   = ADDR_W - 2;

  logic [DATA_W-1:0] mem [DEPTH];

  logic            burst_act;
  logic [HI_W-1:0] base_hi;
  logic [1:0]      base_lo, beat;
  logic            stage_v, out_v;
  logic [DATA_W-1:0] stage_d, out_d;

  wire selected = !ce1_n && ce2 && !ce3_n;
  wire p_req    = !adsp_n && !ce1_n;
  wire c_req    = !p_req && !adsc_n;
  wire strobe   = p_req || c_req;
  wire start    = strobe && selected;
  wire desel    = strobe && !selected;
  wire cont     = !strobe && burst_act;

  logic [LANES-1:0] lane_we;
  assign lane_we = !gw_n ? '1 : (!bwe_n ? ~bw_n : '0);
  wire wr_req = |lane_we;

  wire do_write = !sleep && ((c_req && selected) || cont) && wr_req;
  wire do_read  = !sleep && ((start && (p_req || !wr_req)) || (cont && !wr_req));

  logic [1:0]        beat_nx, lo_base, lo_eff;
  logic [HI_W-1:0]   hi_eff;
  logic [ADDR_W-1:0] acc_addr;

  assign beat_nx  = start ? 2'd0 : ((cont && !adv_n) ? beat + 2'd1 : beat);
  assign lo_base  = start ? addr[1:0] : base_lo;
  assign hi_eff   = start ? addr[ADDR_W-1:2] : base_hi;
  assign lo_eff   = seq_linear ? (lo_base + beat_nx) : (lo_base ^ beat_nx);
  assign acc_addr = {hi_eff, lo_eff};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_act <= 1'b0;
      base_hi   <= '0;
      base_lo   <= '0;
      beat      <= '0;
      stage_v   <= 1'b0;
      stage_d   <= '0;
      out_v     <= 1'b0;
      out_d     <= '0;
    end else begin
      out_v   <= stage_v;
      out_d   <= stage_d;
      stage_v <= do_read;
      if (do_read) stage_d <= mem[acc_addr];
      if (!sleep) begin
        beat <= beat_nx;
        if (start) begin
          burst_act <= 1'b1;
          base_hi   <= addr[ADDR_W-1:2];
          base_lo   <= addr[1:0];
        end else if (desel) begin
          burst_act <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_write) begin
      for (int i = 0; i < LANES; i++) begin
        if (lane_we[i]) mem[acc_addr][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
      end
    end
  end

  assign dq_out   = out_d;
  assign dq_drive = out_v && !oe_n && !sleep;
endmodule

// File: rtl/pburst_sram_chk.sv
module pburst_sram_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sleep,
  input logic             ce1_n,
  input logic             ce2,
  input logic             ce3_n,
  input logic             adsp_n,
  input logic             adsc_n,
  input logic             gw_n,
  input logic             bwe_n,
  input logic [LANES-1:0] bw_n,
  input logic             oe_n,
  input logic             dq_drive
);
  wire sel   = !ce1_n && ce2 && !ce3_n;
  wire p_eff = !adsp_n && !ce1_n;
  wire c_eff = !p_eff && !adsc_n;
  wire dsel  = (p_eff || c_eff) && !sel;
  wire wr_on = !gw_n || (!bwe_n && !(&bw_n));

  always @(negedge clk) begin
    if (!rst_n) begin
      a_r1_reset_quiet: assert (!dq_drive) else $error("R1: drive during reset");
    end
  end

  a_r11_deselect_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    dsel |-> ##2 !dq_drive);

  a_r11_first_cycle_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dsel) && sel && (p_eff || c_eff)) |=> !dq_drive);

  a_r10_read_appears: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && p_eff && !sleep) |-> ##2 (dq_drive || oe_n || sleep));

  a_r7_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && c_eff && wr_on && !sleep) |-> ##2 !dq_drive);

  a_r12_sleep_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> ##2 !dq_drive);
endmodule

bind pburst_sram pburst_sram_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep(sleep), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
  .adsp_n(adsp_n), .adsc_n(adsc_n), .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n),
  .oe_n(oe_n), .dq_drive(dq_drive)
);

// File: tb/tb_pburst_sram.sv
module tb_pburst_sram;
  localparam int AW = 6;
  localparam int DW = 36;
  localparam logic [2:0] SEL = 3'b010;
  localparam logic [2:0] NS2 = 3'b000;

  logic clk = 0, rst_n = 0, sleep = 0;
  logic ce1_n = 1, ce2 = 0, ce3_n = 1, adsp_n = 1, adsc_n = 1, adv_n = 1;
  logic gw_n = 1, bwe_n = 1, seq_linear = 1, oe_n = 0;
  logic [3:0] bw_n = 4'hF;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] dq_out;
  logic dq_drive;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [DW-1:0] m_mem [1<<AW];
  logic m_act = 0, m_st_v = 0, m_out_v = 0;
  logic [DW-1:0] m_st_d = '0, m_out_d = '0;
  logic [AW-3:0] m_hi = '0;
  logic [1:0] m_lo = '0, m_cnt = '0;

  pburst_sram dut (.*);

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    logic sel, pv, cv, acc, wr, nv;
    logic [3:0] ln;
    logic [1:0] lo;
    logic [AW-1:0] a;
    logic [DW-1:0] nd;
    nv = 0; nd = m_st_d; acc = 0; wr = 0; a = '0;
    if (!sleep) begin
      sel = !ce1_n && ce2 && !ce3_n;
      pv  = !adsp_n && !ce1_n;
      cv  = !pv && !adsc_n;
      ln  = !gw_n ? 4'hF : (!bwe_n ? ~bw_n : 4'h0);
      if (pv || cv) begin
        if (sel) begin
          m_act = 1; m_hi = addr[AW-1:2]; m_lo = addr[1:0]; m_cnt = 0;
          a = addr; acc = 1; wr = cv && (ln != 0);
        end else m_act = 0;
      end else if (m_act) begin
        if (!adv_n) m_cnt = m_cnt + 2'd1;
        lo = seq_linear ? (m_lo + m_cnt) : (m_lo ^ m_cnt);
        a = {m_hi, lo}; acc = 1; wr = (ln != 0);
      end
      if (acc && !wr) begin nv = 1; nd = m_mem[a]; end
      if (acc && wr)
        for (int i = 0; i < 4; i++) if (ln[i]) m_mem[a][i*9 +: 9] = wdata[i*9 +: 9];
    end
    m_out_v = m_st_v; m_out_d = m_st_d;
    m_st_v = nv; m_st_d = nd;
  endtask

  task automatic compare(input string tag);
    logic ed;
    ed = m_out_v && !oe_n && !sleep;
    chk(dq_drive == ed, tag, {35'd0, dq_drive}, {35'd0, ed});
    if (ed && dq_drive) chk(dq_out == m_out_d, tag, dq_out, m_out_d);
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic op(input logic [2:0] ce, input logic p, input logic c, input logic v,
                    input logic g, input logic b, input logic [3:0] bw,
                    input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
    {ce1_n, ce2, ce3_n} = ce;
    adsp_n = p; adsc_n = c; adv_n = v; gw_n = g; bwe_n = b; bw_n = bw; addr = a; wdata = d;
    step(tag);
  endtask

  task automatic c_wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
    op(SEL, 1, 0, 1, 0, 1, 4'hF, a, d, tag);
  endtask
  task automatic c_rd(input logic [AW-1:0] a, input string tag);
    op(SEL, 1, 0, 1, 1, 1, 4'hF, a, '0, tag);
  endtask
  task automatic idle(input string tag);
    op(SEL, 1, 1, 1, 1, 1, 4'hF, '0, '0, tag);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240));
    repeat (3) @(negedge clk);
    chk(dq_drive == 1'b0, "R1", {35'd0, dq_drive}, '0);
    rst_n = 1;
    idle("R1");
    chk(dq_drive == 1'b0, "R1", {35'd0, dq_drive}, '0);

    for (int i = 0; i < (1 << AW); i++)
      c_wr(AW'(i), {4{9'(i * 7 + 3)}}, "R7");
    idle("R7");
    c_rd(6'd9, "R7"); idle("R7"); idle("R7");

    op(NS2, 1, 0, 1, 1, 1, 4'hF, 6'd2, '0, "R2");
    op(SEL, 1, 1, 0, 0, 1, 4'hF, 6'd2, 36'h123456789, "R1");
    op(3'b110, 1, 0, 1, 0, 1, 4'hF, 6'd5, 36'hAAAAAAAAA, "R2");
    op(3'b011, 0, 1, 1, 0, 1, 4'hF, 6'd5, 36'hBBBBBBBBB, "R2");
    c_rd(6'd5, "R2"); idle("R2"); idle("R2");
    c_rd(6'd2, "R1"); idle("R1"); idle("R1");

    op(SEL, 1, 0, 1, 0, 0, 4'hF, 6'd12, 36'hF0F0F0F0F, "R8");
    c_rd(6'd12, "R8"); idle("R8"); idle("R8");

    op(SEL, 1, 0, 1, 1, 0, 4'b1010, 6'd13, 36'h111111111, "R9");
    op(SEL, 1, 0, 1, 1, 1, 4'b0000, 6'd13, 36'h222222222, "R9");
    op(SEL, 1, 0, 1, 1, 0, 4'b1111, 6'd13, 36'h333333333, "R9");
    c_rd(6'd13, "R9"); idle("R9"); idle("R9");

    op(SEL, 0, 1, 1, 0, 1, 4'hF, 6'd10, 36'h444444444, "R6");
    op(SEL, 1, 1, 1, 0, 1, 4'hF, 6'd30, 36'h555555555, "R6");
    c_rd(6'd10, "R6"); idle("R6"); idle("R6");

    op(SEL, 0, 0, 1, 0, 1, 4'hF, 6'd20, 36'h666666666, "R3");
    idle("R3");
    c_rd(6'd20, "R3"); idle("R3"); idle("R3");

    for (int m = 0; m < 2; m++) begin
      seq_linear = (m == 0);
      c_rd(6'd22, "R5");
      op(SEL, 1, 1, 0, 1, 1, 4'hF, '0, '0, "R5");
      op(SEL, 1, 1, 1, 1, 1, 4'hF, '0, '0, "R4");
      op(SEL, 1, 1, 0, 1, 1, 4'hF, '0, '0, "R5");
      op(SEL, 1, 1, 0, 0, 1, 4'hF, '0, 36'h777777777, "R4");
      op(SEL, 1, 1, 0, 1, 1, 4'hF, '0, '0, "R5");
      op(SEL, 1, 1, 0, 1, 1, 4'hF, '0, '0, "R5");
      idle("R4"); idle("R4");
    end
    seq_linear = 1;

    c_rd(6'd9, "R11");
    idle("R11");
    #2 oe_n = 1; #1;
    chk(dq_drive == 1'b0, "R11", {35'd0, dq_drive}, '0);
    oe_n = 0; #1;
    chk(dq_drive == 1'b1, "R11", {35'd0, dq_drive}, 36'd1);
    #2 sleep = 1; #1;
    chk(dq_drive == 1'b0, "R12", {35'd0, dq_drive}, '0);
    sleep = 0;
    idle("R11");
    sleep = 1;
    c_wr(6'd9, 36'h999999999, "R12");
    sleep = 0;
    c_rd(6'd9, "R12"); idle("R12"); idle("R12");

    for (int n = 0; n < 4000; n++) begin
      if (n % 300 == 0) seq_linear = $urandom_range(0, 1);
      oe_n  = ($urandom_range(0, 99) < 12);
      sleep = ($urandom_range(0, 99) < 3);
      op(($urandom_range(0, 99) < 85) ? SEL : 3'($urandom_range(0, 7)),
         ($urandom_range(0, 99) >= 15), ($urandom_range(0, 99) >= 20),
         1'($urandom_range(0, 1)), ($urandom_range(0, 99) >= 15),
         ($urandom_range(0, 99) >= 40), 4'($urandom_range(0, 15)),
         6'($urandom_range(0, 63)), {4'($urandom), 32'($urandom)}, "R10");
    end
    sleep = 0; oe_n = 0;
    for (int i = 0; i < (1 << AW); i++) c_rd(AW'(i), "R10");
    idle("R10"); idle("R10");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule